// File: doc/BRIEF.md
# Quadrature Encoder Input Front End

This block sits between the A, B and index pins of one encoder channel and the counter core. It turns the pin activity into a one-cycle count-enable strobe with a direction bit, plus an index strobe. The counter arithmetic itself lives elsewhere.

In quadrature mode, each of A and B passes through a persistence filter. The filtered pair is then decoded as a Gray-code position at one, two or four counts per encoder cycle. A step in which both filtered inputs change together is not a legal Gray-code step, so it sets a sticky noise flag. The host clears that flag when it loads the count. In clock/direction mode the filter and decoder are bypassed: a rising edge on A is a count, and B gives its direction.

The index strobe has two forms. In direct form it follows a low index level. In synchronous form it fires together with a decoded count while the index sits at a programmed level. Synchronous form is only allowed in quadrature mode.

Top module: `qenc_front_end`

## Requirements
- R1: With `cfg_quad_en` = 0, each rising edge of `enc_a` gives exactly one `cnt_en` pulse, one cycle after the edge is sampled. On that pulse `cnt_up` equals the `enc_b` level sampled at the edge (1 = up, 0 = down). A held high level gives no further pulses, and all outputs are low after reset.
- R2: In quadrature mode a level change on A or B reaches the decoder only after the new level has been sampled on `cfg_filt_len` consecutive clocks. A length of 0 acts as 1, and shorter excursions are dropped.
- R3: Scale code 2 or 3 (x4): every legal filtered step gives one count. The sequence AB = 00→10→11→01→00 (A leading) counts up, and the reverse sequence counts down.
- R4: Scale code 1 (x2): only steps in which A changes are counted, giving two counts per encoder cycle.
- R5: Scale code 0 (x1): one count per encoder cycle. It counts up on 00→10 and down on 10→00.
- R6: A filtered step in which A and B change together gives no count and sets `noise_err`. The flag stays set until it is cleared.
- R7: `noise_clr` clears `noise_err` one cycle later. A new noise event in the same cycle wins over the clear.
- R8: With `cfg_quad_en` = 0, `noise_err` is never raised, whatever the inputs do.
- R9: With `cfg_ab_en` = 0, no `cnt_en` pulse is produced in either mode.
- R10: With synchronous index off, `idx_strobe` is the inverse of `enc_idx`, registered once. `cfg_idx_pol` has no effect.
- R11: With synchronous index on in quadrature mode, `idx_strobe` pulses only in a `cnt_en` cycle whose count came from a step taken while `enc_idx` equalled `cfg_idx_pol`.
- R12: With `cfg_quad_en` = 0, the index behaves as in R10 even when `cfg_sync_idx` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the filter sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_quad_en | input | 1 | 1 = quadrature decode, 0 = clock/direction bypass |
| cfg_scale | input | 2 | Resolution: 0 = x1, 1 = x2, 2 or 3 = x4 |
| cfg_ab_en | input | 1 | Enables counting from A/B |
| cfg_sync_idx | input | 1 | Requests synchronous index form |
| cfg_idx_pol | input | 1 | Active index level in synchronous form |
| cfg_filt_len | input | FILT_W | Consecutive samples needed to accept a change |
| noise_clr | input | 1 | Clears the noise flag (host count load) |
| enc_a | input | 1 | Encoder A, synchronous to clk |
| enc_b | input | 1 | Encoder B, synchronous to clk |
| enc_idx | input | 1 | Encoder index, synchronous to clk |
| cnt_en | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Direction of the count on cnt_en (1 = up) |
| noise_err | output | 1 | Sticky illegal-transition flag |
| idx_strobe | output | 1 | Index function strobe |

## Verification
All results are registered, so latency is fixed by the path a stimulus takes. In bypass mode a count, its direction and the direct index strobe appear one clock after the edge that samples the input. In quadrature mode a count, and any noise flag or synchronous index strobe tied to it, appears `cfg_filt_len` + 1 clocks after the first edge that samples the new level (length 0 counts as 1). A clear takes effect one clock after `noise_clr` is sampled. The reference model applies these same edge counts behaviourally and is compared with the outputs at every falling edge. Directed per-phase totals of up counts, down counts and index strobes then confirm the per-cycle resolution figures.

// File: rtl/qfe_pkg.sv
// Shared types for the quadrature front end.
package qfe_pkg;

    // Decode resolution selector; code 3 is an alias of x4.
    typedef enum logic [1:0] {
        RES_X1     = 2'd0,
        RES_X2     = 2'd1,
        RES_X4     = 2'd2,
        RES_X4_ALT = 2'd3
    } res_e;

    localparam int unsigned ENC_LINES = 2;  // A and B

endpackage

// File: rtl/qfe_glitch_filter.sv
// Persistence filter for one encoder line.
// Output takes a new level only after the raw input has shown that level
// on LEN consecutive clocks (LEN of 0 behaves as 1).
// Assumes raw is already synchronous to clk.
module qfe_glitch_filter #(
    parameter int unsigned FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] len,
    input  logic          raw,
    output logic          filt
);
    logic [FW-1:0] run;
    logic [FW:0]   run_nx;
    logic          reached;

    assign run_nx  = {1'b0, run} + 1'b1;
    assign reached = run_nx >= {1'b0, len};

    // Count consecutive samples differing from the output; commit at LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            run  <= '0;
        end else if (raw == filt) begin
            run <= '0;
        end else if (reached) begin
            filt <= raw;
            run  <= '0;
        end else begin
            run <= run_nx[FW-1:0];
        end
    end

    // R2: the output only ever moves to a level the input actually had.
    a_r2_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (filt == $past(raw)));

endmodule

// File: rtl/qfe_step_decoder.sv
// Step decoder and noise flag.
// Quadrature mode: compares the filtered A/B pair with its previous value,
// classifies the step and selects counts by resolution.
// Bypass mode: rising raw A is a count, raw B the direction.
// Exports next-cycle count pulse for the index unit.
module qfe_step_decoder
    import qfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic quad_en,
    input  res_e res,
    input  logic ab_en,
    input  logic noise_clr,
    input  logic fa,
    input  logic fb,
    input  logic raw_a,
    input  logic raw_b,
    output logic pulse_nx,
    output logic cnt_en,
    output logic cnt_up,
    output logic noise_err
);
    logic pa, pb, ra_q;
    logic chg_a, chg_b, single, both;
    logic q_hit, q_up, nq_hit;
    logic up_nx, noise_set;

    // Previous filtered pair and previous raw A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa   <= 1'b0;
            pb   <= 1'b0;
            ra_q <= 1'b0;
        end else begin
            pa   <= fa;
            pb   <= fb;
            ra_q <= raw_a;
        end
    end

    // Step classification and resolution selection.
    always_comb begin
        chg_a  = fa ^ pa;
        chg_b  = fb ^ pb;
        single = chg_a ^ chg_b;
        both   = chg_a & chg_b;
        q_up   = fa ^ pb;
        unique case (res)
            RES_X1:  q_hit = single & chg_a & ~fb;
            RES_X2:  q_hit = single & chg_a;
            default: q_hit = single;
        endcase
        nq_hit    = raw_a & ~ra_q;
        pulse_nx  = ab_en & (quad_en ? q_hit : nq_hit);
        up_nx     = quad_en ? q_up : raw_b;
        noise_set = quad_en & both;
    end

    // Registered count strobe, direction and sticky noise flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en    <= 1'b0;
            cnt_up    <= 1'b0;
            noise_err <= 1'b0;
        end else begin
            cnt_en    <= pulse_nx;
            cnt_up    <= up_nx;
            noise_err <= noise_set | (noise_err & ~noise_clr);
        end
    end

    // R6: the flag holds while no clear is applied.
    a_r6_noise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(noise_err) && !$past(noise_clr)) |-> noise_err);
    // R8: the flag only rises out of quadrature mode never.
    a_r8_no_noise_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_err) |-> $past(quad_en));
    // R9: a count strobe needs the inputs enabled the cycle before.
    a_r9_gated_counts: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |-> $past(ab_en));

endmodule

// File: rtl/qfe_index_unit.sv
// Index strobe generator.
// Direct form: strobe follows a low index level.
// Synchronous form (only when quadrature mode is on): strobe rides on the
// decoder's next-cycle count pulse while index equals the polarity bit.
module qfe_index_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic quad_en,
    input  logic sync_req,
    input  logic pol,
    input  logic idx,
    input  logic pulse_nx,
    output logic idx_strobe
);
    logic sync_eff;

    assign sync_eff = sync_req & quad_en;

    // Register the selected index function.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_strobe <= 1'b0;
        end else if (sync_eff) begin
            idx_strobe <= pulse_nx & (idx ~^ pol);
        end else begin
            idx_strobe <= ~idx;
        end
    end

endmodule

// File: rtl/qenc_front_end.sv
// One-channel quadrature encoder front end.
// Filters A/B, decodes them (or bypasses in clock/direction mode), flags
// illegal two-line steps and produces the index strobe.
// Assumes all encoder inputs are already synchronous to clk.
module qenc_front_end
    import qfe_pkg::*;
#(
    parameter int unsigned FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_quad_en,
    input  logic [1:0]        cfg_scale,
    input  logic              cfg_ab_en,
    input  logic              cfg_sync_idx,
    input  logic              cfg_idx_pol,
    input  logic [FILT_W-1:0] cfg_filt_len,
    input  logic              noise_clr,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_idx,
    output logic              cnt_en,
    output logic              cnt_up,
    output logic              noise_err,
    output logic              idx_strobe
);
    logic [ENC_LINES-1:0] raw_lines;
    logic [ENC_LINES-1:0] filt_lines;
    logic                 pulse_nx;
    res_e                 res_eff;

    assign raw_lines = {enc_b, enc_a};
    // Bypass mode forces x1 resolution.
    assign res_eff   = cfg_quad_en ? res_e'(cfg_scale) : RES_X1;

    for (genvar g = 0; g < ENC_LINES; g++) begin : g_filt
        qfe_glitch_filter #(.FW(FILT_W)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .len  (cfg_filt_len),
            .raw  (raw_lines[g]),
            .filt (filt_lines[g])
        );
    end

    qfe_step_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .quad_en  (cfg_quad_en),
        .res      (res_eff),
        .ab_en    (cfg_ab_en),
        .noise_clr(noise_clr),
        .fa       (filt_lines[0]),
        .fb       (filt_lines[1]),
        .raw_a    (enc_a),
        .raw_b    (enc_b),
        .pulse_nx (pulse_nx),
        .cnt_en   (cnt_en),
        .cnt_up   (cnt_up),
        .noise_err(noise_err)
    );

    qfe_index_unit u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .quad_en   (cfg_quad_en),
        .sync_req  (cfg_sync_idx),
        .pol       (cfg_idx_pol),
        .idx       (enc_idx),
        .pulse_nx  (pulse_nx),
        .idx_strobe(idx_strobe)
    );

    // R11: a synchronous index strobe coincides with a count strobe.
    a_r11_sync_with_count: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_strobe && $past(cfg_sync_idx && cfg_quad_en)) |-> cnt_en);
    // R12: in bypass mode the strobe reflects a low index level.
    a_r12_bypass_direct_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_strobe && !$past(cfg_quad_en)) |-> !$past(enc_idx));

endmodule

// File: tb/qenc_front_end_test.sv
module qenc_front_end_test;
    localparam int CLK_PERIOD = 10;
    localparam int FW         = 4;
    localparam int WD_LIMIT   = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_quad_en = 1'b0;
    logic [1:0]    cfg_scale = 2'd0;
    logic          cfg_ab_en = 1'b1;
    logic          cfg_sync_idx = 1'b0;
    logic          cfg_idx_pol = 1'b0;
    logic [FW-1:0] cfg_filt_len = '0;
    logic          noise_clr = 1'b0;
    logic          enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b1;
    logic          cnt_en, cnt_up, noise_err, idx_strobe;

    int    n_vec = 0, n_fail = 0, cyc = 0;
    int    ups = 0, dns = 0, strobes = 0;
    bit    started = 0, done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_front_end #(.FILT_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_quad_en(cfg_quad_en), .cfg_scale(cfg_scale),
        .cfg_ab_en(cfg_ab_en), .cfg_sync_idx(cfg_sync_idx), .cfg_idx_pol(cfg_idx_pol),
        .cfg_filt_len(cfg_filt_len), .noise_clr(noise_clr), .enc_a(enc_a),
        .enc_b(enc_b), .enc_idx(enc_idx), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .noise_err(noise_err), .idx_strobe(idx_strobe)
    );

    // ---------------- behavioural reference model ----------------
    bit m_en, m_up, m_noise, m_idx;
    bit mfa, mfb, mpa, mpb, mra;
    int run_a, run_b;

    function automatic int gpos(bit a, bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        int po, pn, d, need;
        bit qhit, up, nz, hit;
        if (!rst_n) begin
            {m_en, m_up, m_noise, m_idx, mfa, mfb, mpa, mpb, mra} = '0;
            run_a = 0; run_b = 0;
        end else begin
            qhit = 0; up = 0; nz = 0;
            po = gpos(mpa, mpb);
            pn = gpos(mfa, mfb);
            if (po != pn) begin
                d = (pn - po + 4) % 4;
                if (d == 2) nz = 1;
                else begin
                    up = (d == 1);
                    case (cfg_scale)
                        2'd0:    qhit = up ? (pn == 1) : (po == 1);
                        2'd1:    qhit = up ? (pn % 2 == 1) : (po % 2 == 1);
                        default: qhit = 1;
                    endcase
                end
            end
            hit = cfg_ab_en && (cfg_quad_en ? qhit : (enc_a && !mra));
            m_idx = (cfg_sync_idx && cfg_quad_en) ? (hit && (enc_idx == cfg_idx_pol)) : !enc_idx;
            m_up  = cfg_quad_en ? up : enc_b;
            m_en  = hit;
            m_noise = (cfg_quad_en && nz) || (m_noise && !noise_clr);
            mpa = mfa; mpb = mfb; mra = enc_a;
            need = (cfg_filt_len == 0) ? 1 : int'(cfg_filt_len);
            if (enc_a == mfa) run_a = 0;
            else begin run_a++; if (run_a >= need) begin mfa = enc_a; run_a = 0; end end
            if (enc_b == mfb) run_b = 0;
            else begin run_b++; if (run_b >= need) begin mfb = enc_b; run_b = 0; end end
        end
        started = 1;
        cyc++;
    end

    // Compare every cycle away from the active edge; tally observed events.
    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if (cnt_en !== m_en) begin n_fail++; $display("FAIL %s: cnt_en got %0b expected %0b", cur_req, cnt_en, m_en); end
            if (m_en && cnt_up !== m_up) begin n_fail++; $display("FAIL %s: cnt_up got %0b expected %0b", cur_req, cnt_up, m_up); end
            if (noise_err !== m_noise) begin n_fail++; $display("FAIL %s: noise_err got %0b expected %0b", cur_req, noise_err, m_noise); end
            if (idx_strobe !== m_idx) begin n_fail++; $display("FAIL %s: idx_strobe got %0b expected %0b", cur_req, idx_strobe, m_idx); end
            if (cnt_en === 1'b1 && cnt_up === 1'b1) ups++;
            if (cnt_en === 1'b1 && cnt_up === 1'b0) dns++;
            if (idx_strobe === 1'b1) strobes++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check_val(string req, string what, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Apply an AB level pair and hold long enough to pass the filter.
    task automatic ab(bit a, bit b);
        enc_a = a; enc_b = b;
        tick(int'(cfg_filt_len) + 3);
    endtask

    task automatic summary();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WD_LIMIT && !done) begin
            n_fail++;
            $display("FAIL watchdog: cycles got %0d expected below %0d", cyc, WD_LIMIT);
            summary();
        end
    end

    initial begin
        int u0, d0, s0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check_val("R1", "outputs after reset", {cnt_en, noise_err}, 0);

        // R1: clock/direction bypass
        cur_req = "R1";
        u0 = ups; d0 = dns;
        enc_b = 1;
        repeat (3) begin enc_a = 1; tick(3); enc_a = 0; tick(2); end
        enc_b = 0;
        repeat (2) begin enc_a = 1; tick(1); enc_a = 0; tick(1); end
        tick(2);
        check_val("R1", "bypass up counts", ups - u0, 3);
        check_val("R1", "bypass down counts", dns - d0, 2);

        // R8: simultaneous A/B flips in bypass raise no flag
        cur_req = "R8";
        repeat (4) begin enc_a = 1; enc_b = 1; tick(2); enc_a = 0; enc_b = 0; tick(2); end
        check_val("R8", "noise in bypass", noise_err, 0);

        // R12: sync request ignored in bypass; low index strobes directly
        cur_req = "R12";
        cfg_sync_idx = 1; cfg_idx_pol = 1;
        s0 = strobes;
        enc_idx = 0; tick(3); enc_idx = 1; tick(2);
        check_val("R12", "bypass index strobes", strobes - s0, 3);
        cfg_sync_idx = 0;

        // R3: x4 quadrature with filter length 3
        cur_req = "R3";
        cfg_quad_en = 1; cfg_scale = 2'd2; cfg_filt_len = 3;
        tick(4);
        u0 = ups; d0 = dns;
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        check_val("R3", "x4 up counts", ups - u0, 4);
        ab(0,1); ab(1,1); ab(1,0); ab(0,0);
        check_val("R3", "x4 down counts", dns - d0, 4);
        cfg_scale = 2'd3;
        u0 = ups;
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        check_val("R3", "x4 alias up counts", ups - u0, 4);

        // R2: a pulse shorter than the filter length is dropped
        cur_req = "R2";
        u0 = ups; d0 = dns;
        enc_a = 1; tick(2); enc_a = 0; tick(6);
        check_val("R2", "glitch counts", (ups - u0) + (dns - d0), 0);
        cfg_filt_len = 0;
        u0 = ups;
        ab(1,0);
        check_val("R2", "length zero counts", ups - u0, 1);
        ab(0,0);
        cfg_filt_len = 3;
        tick(2);

        // R4: x2
        cur_req = "R4";
        cfg_scale = 2'd1;
        u0 = ups; d0 = dns;
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        check_val("R4", "x2 up counts", ups - u0, 2);
        ab(0,1); ab(1,1); ab(1,0); ab(0,0);
        check_val("R4", "x2 down counts", dns - d0, 2);

        // R5: x1
        cur_req = "R5";
        cfg_scale = 2'd0;
        u0 = ups; d0 = dns;
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        check_val("R5", "x1 up counts", ups - u0, 2);
        ab(0,1); ab(1,1); ab(1,0); ab(0,0);
        check_val("R5", "x1 down counts", dns - d0, 1);

        // R6: illegal two-line step
        cur_req = "R6";
        cfg_scale = 2'd2;
        u0 = ups; d0 = dns;
        ab(1,1);
        check_val("R6", "noise flag", noise_err, 1);
        check_val("R6", "counts on illegal step", (ups - u0) + (dns - d0), 0);
        ab(0,1); ab(0,0);
        check_val("R6", "flag sticky", noise_err, 1);

        // R7: clear
        cur_req = "R7";
        noise_clr = 1; tick(1); noise_clr = 0; tick(1);
        check_val("R7", "flag after clear", noise_err, 0);
        // R7: a new event at the clear cycle wins
        enc_a = 1; enc_b = 1; tick(3);
        noise_clr = 1; tick(1); noise_clr = 0; tick(2);
        check_val("R7", "set beats clear", noise_err, 1);
        ab(0,1); ab(0,0);
        noise_clr = 1; tick(1); noise_clr = 0; tick(1);

        // R9: inputs disabled
        cur_req = "R9";
        cfg_ab_en = 0;
        u0 = ups; d0 = dns;
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        cfg_quad_en = 0;
        enc_a = 1; tick(2); enc_a = 0; tick(2);
        check_val("R9", "disabled counts", (ups - u0) + (dns - d0), 0);
        cfg_quad_en = 1; cfg_ab_en = 1;
        tick(4);

        // R10: direct index, polarity ignored
        cur_req = "R10";
        cfg_idx_pol = 1;
        s0 = strobes;
        enc_idx = 0; tick(2); enc_idx = 1; tick(3);
        check_val("R10", "direct index strobes", strobes - s0, 2);

        // R11: synchronous index
        cur_req = "R11";
        enc_idx = 0; cfg_sync_idx = 1; cfg_idx_pol = 1;
        tick(2);
        s0 = strobes;
        ab(1,0); ab(1,1);
        check_val("R11", "strobes while inactive", strobes - s0, 0);
        enc_idx = 1;
        ab(0,1); ab(0,0);
        tick(3);
        check_val("R11", "strobes while active", strobes - s0, 2);
        enc_idx = 0; cfg_idx_pol = 0;
        s0 = strobes;
        ab(1,0);
        enc_idx = 1;
        tick(3);
        check_val("R11", "low polarity strobes", strobes - s0, 1);

        tick(4);
        summary();
    end

endmodule